// File: doc/BRIEF.md
# Memory Operand Address Generator

This block turns the 16-bit addressing byte of an x86-style instruction into a memory operand address. The caller raises `start` for one cycle and supplies the addressing byte, the four base and index registers, the current instruction pointer, the code, data and stack segment bases, and an optional segment override. The block captures all of these on the start edge. When the addressing form carries a displacement, the block reads one or two bytes from the code stream through a byte-wide request/valid port. It then raises `done` for one cycle.

The block returns three results. The first is the wrapped 16-bit offset, which is the load-effective-address value. The second is the chosen segment base. The third is the linear address, which is that base plus the offset. The block also reports the instruction pointer after the displacement bytes. Register-direct operands are not translated: they only raise an error flag.

Top module: `ea_addr_gen`

## Requirements
- R1: The r/m field (bits 2:0) selects the base sum: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX. The exception is mode 0 (bits 7:6) with r/m 6, which has no base register and only a 16-bit displacement.
- R2: Without an override, forms that use BP (r/m 2, 3, and r/m 6 in modes 1 and 2) select the stack segment base. Every other form selects the data segment base, and this includes the direct form.
- R3: When `seg_ovr_en` is high at start, `seg_ovr_base` replaces the default segment base.
- R4: Mode 1 reads one displacement byte, sign-extends it to 16 bits and advances the instruction pointer by 1.
- R5: Mode 2 and the direct form read a 16-bit displacement, low byte at IP and high byte at IP+1, and advance the instruction pointer by 2.
- R6: Forms without a displacement issue no read and leave the instruction pointer unchanged. They raise `done` in the first cycle after the start edge.
- R7: The offset is base sum plus displacement modulo 2^16. `ea_linear` is the segment base plus that offset, modulo 2^ADDR_W.
- R8: Each code read addresses code segment base + IP for the first byte and code segment base + ((IP+1) mod 2^16) for the second.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen. A `rd_valid` pulse while no read is requested has no effect.
- R10: `done` lasts exactly one cycle. All results hold their values until the next accepted start.
- R11: Mode 3 sets `err`, issues no read and returns the instruction pointer unchanged.
- R12: A `start` pulse while an operation is in progress is ignored.
- R13: After reset, `done`, `rd_req`, `err` and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (captures all operands) |
| addr_byte | input | 8 | Addressing byte: mode in 7:6, r/m in 2:0 |
| reg_bx | input | 16 | BX register |
| reg_bp | input | 16 | BP register |
| reg_si | input | 16 | SI register |
| reg_di | input | 16 | DI register |
| ip_in | input | 16 | Instruction pointer at the first displacement byte |
| cs_base | input | ADDR_W | Code segment base |
| ds_base | input | ADDR_W | Data segment base |
| ss_base | input | ADDR_W | Stack segment base |
| seg_ovr_en | input | 1 | Use the override base instead of the default |
| seg_ovr_base | input | ADDR_W | Override segment base |
| rd_req | output | 1 | Code byte read request |
| rd_addr | output | ADDR_W | Code byte read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Register-direct (mode 3) form was given |
| ea_offset | output | 16 | Wrapped effective offset |
| ea_seg | output | ADDR_W | Selected segment base |
| ea_linear | output | ADDR_W | Segment base plus offset |
| ip_out | output | 16 | Instruction pointer after the displacement |

## Verification
The properties assume that `rd_valid` comes only from a responder that answers a pending request. A stray pulse outside a request is allowed, and the design must discard it. They also assume that `start` is a single-cycle pulse, which may arrive during an operation. The bench's responder answers each request after a random latency of zero to two cycles, or after a forced longer latency so that a start pulse can land in the middle of a fetch. Register and segment values come from a fixed-seed generator. Directed cases cover the 16-bit and 24-bit wrap points and a negative byte displacement.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_LO = 2'd1,
    ST_FETCH_HI = 2'd2,
    ST_DONE     = 2'd3
  } ea_state_t;

  // Displacement size implied by mode and r/m.
  function automatic disp_kind_t disp_kind(input logic [1:0] mode, input logic [2:0] rm);
    disp_kind_t k;
    case (mode)
      2'd0:    k = (rm == 3'd6) ? DISP_WORD : DISP_NONE;
      2'd1:    k = DISP_BYTE;
      2'd2:    k = DISP_WORD;
      default: k = DISP_NONE;
    endcase
    return k;
  endfunction

  // Sum of base and index registers, wrapped to 16 bits.
  function automatic logic [15:0] base_sum(input logic [1:0] mode, input logic [2:0] rm,
                                           input logic [15:0] bx, input logic [15:0] bp,
                                           input logic [15:0] si, input logic [15:0] di);
    logic [15:0] s;
    case (rm)
      3'd0:    s = bx + si;
      3'd1:    s = bx + di;
      3'd2:    s = bp + si;
      3'd3:    s = bp + di;
      3'd4:    s = si;
      3'd5:    s = di;
      3'd6:    s = (mode == 2'd0) ? 16'h0000 : bp;
      default: s = bx;
    endcase
    return s;
  endfunction

  // True for the forms whose default segment is the stack segment.
  function automatic logic stack_form(input logic [1:0] mode, input logic [2:0] rm);
    return (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && (mode != 2'd0));
  endfunction

  // Displacement value after sign or zero handling.
  function automatic logic [15:0] disp_value(input disp_kind_t k, input logic [7:0] lo,
                                             input logic [7:0] hi);
    logic [15:0] d;
    case (k)
      DISP_BYTE: d = {{8{lo[7]}}, lo};
      DISP_WORD: d = {hi, lo};
      default:   d = 16'h0000;
    endcase
    return d;
  endfunction

  // Instruction pointer step for a displacement kind.
  function automatic logic [15:0] ip_step(input disp_kind_t k);
    return (k == DISP_BYTE) ? 16'd1 : (k == DISP_WORD) ? 16'd2 : 16'd0;
  endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic [2:0]  rm,
  input  logic [15:0] bx,
  input  logic [15:0] bp,
  input  logic [15:0] si,
  input  logic [15:0] di,
  output logic [15:0] sum,
  output logic        use_stack,
  output disp_kind_t  kind,
  output logic        is_reg
);

  always_comb begin
    sum       = base_sum(mode, rm, bx, bp, si, di);
    use_stack = stack_form(mode, rm);
    kind      = disp_kind(mode, rm);
    is_reg    = (mode == 2'd3);
  end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  disp_kind_t        kind_new,
  input  disp_kind_t        kind_q,
  input  logic [ADDR_W-1:0] cs_q,
  input  logic [15:0]       ip_q,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        disp_lo,
  output logic [7:0]        disp_hi,
  output logic              done,
  output logic              accept,
  output logic              busy,
  output logic              lo_take,
  output logic              hi_take
);

  ea_state_t state;
  logic [15:0] ip_fetch;
  logic [ADDR_W-1:0] ip_ext;

  assign accept  = (state == ST_IDLE) && start;
  assign busy    = (state != ST_IDLE);
  assign lo_take = (state == ST_FETCH_LO) && rd_valid;
  assign hi_take = (state == ST_FETCH_HI) && rd_valid;
  assign rd_req  = (state == ST_FETCH_LO) || (state == ST_FETCH_HI);
  assign done    = (state == ST_DONE);

  assign ip_fetch = (state == ST_FETCH_HI) ? ip_q + 16'd1 : ip_q;

  generate
    if (ADDR_W > 16) begin : g_wide
      assign ip_ext = {{(ADDR_W-16){1'b0}}, ip_fetch};
    end else begin : g_narrow
      assign ip_ext = ip_fetch;
    end
  endgenerate

  assign rd_addr = cs_q + ip_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      disp_lo <= 8'h00;
      disp_hi <= 8'h00;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            disp_lo <= 8'h00;
            disp_hi <= 8'h00;
            state   <= (kind_new == DISP_NONE) ? ST_DONE : ST_FETCH_LO;
          end
        end
        ST_FETCH_LO: begin
          if (rd_valid) begin
            disp_lo <= rd_data;
            state   <= (kind_q == DISP_WORD) ? ST_FETCH_HI : ST_DONE;
          end
        end
        ST_FETCH_HI: begin
          if (rd_valid) begin
            disp_hi <= rd_data;
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ea_combine.sv
module ea_combine
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [15:0]       sum,
  input  logic              use_stack,
  input  disp_kind_t        kind,
  input  logic [7:0]        disp_lo,
  input  logic [7:0]        disp_hi,
  input  logic              ovr_en,
  input  logic [ADDR_W-1:0] ovr_base,
  input  logic [ADDR_W-1:0] ds_q,
  input  logic [ADDR_W-1:0] ss_q,
  input  logic [15:0]       ip_q,
  output logic [15:0]       offset,
  output logic [ADDR_W-1:0] seg,
  output logic [ADDR_W-1:0] linear,
  output logic [15:0]       ip_next
);

  logic [ADDR_W-1:0] off_ext;

  assign offset  = sum + disp_value(kind, disp_lo, disp_hi);
  assign seg     = ovr_en ? ovr_base : (use_stack ? ss_q : ds_q);
  assign ip_next = ip_q + ip_step(kind);

  generate
    if (ADDR_W > 16) begin : g_wide
      assign off_ext = {{(ADDR_W-16){1'b0}}, offset};
    end else begin : g_narrow
      assign off_ext = offset;
    end
  endgenerate

  assign linear = seg + off_ext;

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        addr_byte,
  input  logic [15:0]       reg_bx,
  input  logic [15:0]       reg_bp,
  input  logic [15:0]       reg_si,
  input  logic [15:0]       reg_di,
  input  logic [15:0]       ip_in,
  input  logic [ADDR_W-1:0] cs_base,
  input  logic [ADDR_W-1:0] ds_base,
  input  logic [ADDR_W-1:0] ss_base,
  input  logic              seg_ovr_en,
  input  logic [ADDR_W-1:0] seg_ovr_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              err,
  output logic [15:0]       ea_offset,
  output logic [ADDR_W-1:0] ea_seg,
  output logic [ADDR_W-1:0] ea_linear,
  output logic [15:0]       ip_out
);

  // Operands captured on an accepted start.
  logic [1:0]        mode_q;
  logic [2:0]        rm_q;
  logic [15:0]       bx_q, bp_q, si_q, di_q, ip_q;
  logic [ADDR_W-1:0] cs_q, ds_q, ss_q, ovr_q;
  logic              ovr_en_q;

  // Internal events, visible to the checker.
  logic              accept, busy, lo_take, hi_take;
  logic [15:0]       sum;
  logic              use_stack, is_reg;
  disp_kind_t        kind_q, kind_new;
  logic [7:0]        disp_lo, disp_hi;
  logic              unused_reg_field;

  assign unused_reg_field = ^addr_byte[5:3];
  assign kind_new = disp_kind(addr_byte[7:6], addr_byte[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'd0;
      rm_q     <= 3'd0;
      bx_q     <= 16'h0;
      bp_q     <= 16'h0;
      si_q     <= 16'h0;
      di_q     <= 16'h0;
      ip_q     <= 16'h0;
      cs_q     <= '0;
      ds_q     <= '0;
      ss_q     <= '0;
      ovr_q    <= '0;
      ovr_en_q <= 1'b0;
    end else if (accept) begin
      mode_q   <= addr_byte[7:6];
      rm_q     <= addr_byte[2:0];
      bx_q     <= reg_bx;
      bp_q     <= reg_bp;
      si_q     <= reg_si;
      di_q     <= reg_di;
      ip_q     <= ip_in;
      cs_q     <= cs_base;
      ds_q     <= ds_base;
      ss_q     <= ss_base;
      ovr_q    <= seg_ovr_base;
      ovr_en_q <= seg_ovr_en;
    end
  end

  ea_decode u_dec (
    .mode      (mode_q),
    .rm        (rm_q),
    .bx        (bx_q),
    .bp        (bp_q),
    .si        (si_q),
    .di        (di_q),
    .sum       (sum),
    .use_stack (use_stack),
    .kind      (kind_q),
    .is_reg    (is_reg)
  );

  ea_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind_new (kind_new),
    .kind_q   (kind_q),
    .cs_q     (cs_q),
    .ip_q     (ip_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .disp_lo  (disp_lo),
    .disp_hi  (disp_hi),
    .done     (done),
    .accept   (accept),
    .busy     (busy),
    .lo_take  (lo_take),
    .hi_take  (hi_take)
  );

  ea_combine #(.ADDR_W(ADDR_W)) u_comb (
    .sum       (sum),
    .use_stack (use_stack),
    .kind      (kind_q),
    .disp_lo   (disp_lo),
    .disp_hi   (disp_hi),
    .ovr_en    (ovr_en_q),
    .ovr_base  (ovr_q),
    .ds_q      (ds_q),
    .ss_q      (ss_q),
    .ip_q      (ip_q),
    .offset    (ea_offset),
    .seg       (ea_seg),
    .linear    (ea_linear),
    .ip_next   (ip_out)
  );

  assign err = is_reg;

endmodule

// File: rtl/ea_addr_gen_chk.sv
module ea_addr_gen_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              err,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [15:0]       ea_offset,
  input logic [ADDR_W-1:0] ea_linear,
  input logic [15:0]       ip_out,
  input logic [15:0]       ip_q,
  input logic              busy,
  input logic              lo_take,
  input logic              hi_take
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R11
  reg_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_req);

  // R11
  reg_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (ip_out == ip_q));

  // R5
  ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ip_out - ip_q) <= 16'd2));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> ($stable(ea_linear) && $stable(ea_offset)));

  // R12
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ip_q));

  // R9
  take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_take, hi_take, done}));

endmodule

bind ea_addr_gen ea_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .err       (err),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .ea_offset (ea_offset),
  .ea_linear (ea_linear),
  .ip_out    (ip_out),
  .ip_q      (ip_q),
  .busy      (busy),
  .lo_take   (lo_take),
  .hi_take   (hi_take)
);

// File: tb/ea_addr_gen_test.sv
`timescale 1ns/1ps
module ea_addr_gen_test;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    addr_byte = 8'h00;
  logic [15:0]   reg_bx = 0, reg_bp = 0, reg_si = 0, reg_di = 0, ip_in = 0;
  logic [AW-1:0] cs_base = 0, ds_base = 0, ss_base = 0, seg_ovr_base = 0;
  logic          seg_ovr_en = 1'b0;
  logic          rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = 8'h00;
  logic          done, err;
  logic [15:0]   ea_offset, ip_out;
  logic [AW-1:0] ea_seg, ea_linear;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // responder controls
  int  lat = 0;
  int  force_lat = -1;
  bit  spur_en = 0;
  bit  poke_en = 0;
  logic [AW-1:0] poke_addr = 0;
  logic [7:0]    poke_val = 0;

  // observed fetches
  int nfetch = 0;
  logic [AW-1:0] fa0, fa1;

  ea_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_byte(addr_byte),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .ip_in(ip_in), .cs_base(cs_base), .ds_base(ds_base), .ss_base(ss_base),
    .seg_ovr_en(seg_ovr_en), .seg_ovr_base(seg_ovr_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err(err), .ea_offset(ea_offset), .ea_seg(ea_seg),
    .ea_linear(ea_linear), .ip_out(ip_out)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] code_byte(input logic [AW-1:0] a);
    if (poke_en && a == poke_addr) return poke_val;
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5C;
  endfunction

  // Responder: answers a pending request after a latency.
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req && !rd_valid) begin
      if (lat <= 0) begin
        rd_valid <= 1'b1;
        rd_data  <= code_byte(rd_addr);
        lat      <= (force_lat >= 0) ? force_lat : int'($urandom % 3);
      end else begin
        lat <= lat - 1;
      end
    end else if (!rd_req && spur_en) begin
      rd_valid <= 1'b1;
      rd_data  <= 8'hA5;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req && rd_valid) begin
      if (nfetch == 0) fa0 <= rd_addr;
      else fa1 <= rd_addr;
      nfetch <= nfetch + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    summary();
  end

  // Run one operation and check every result against the bench model.
  task automatic run_op(input logic [7:0] ab, input logic [15:0] bx, input logic [15:0] bp,
                        input logic [15:0] si, input logic [15:0] di, input logic [15:0] ip,
                        input logic [AW-1:0] cs, input logic [AW-1:0] ds,
                        input logic [AW-1:0] ss, input bit oe, input logic [AW-1:0] ob,
                        input bit mid_start);
    logic [1:0] mode;
    logic [2:0] rm;
    int nbytes, n;
    bit use_bp;
    logic [15:0] base, disp, off, ipx;
    logic [AW-1:0] a0, a1, seg, lin;
    logic [7:0] b0, b1;
    mode = ab[7:6];
    rm   = ab[2:0];
    base = 0;
    if (rm == 0 || rm == 1 || rm == 7) base = base + bx;
    if (rm == 0 || rm == 2 || rm == 4) base = base + si;
    if (rm == 1 || rm == 3 || rm == 5) base = base + di;
    use_bp = (rm == 2 || rm == 3 || (rm == 6 && mode != 0));
    if (use_bp) base = base + bp;
    nbytes = (mode == 1) ? 1 : (mode == 2 || (mode == 0 && rm == 6)) ? 2 : 0;
    ipx = ip + 16'd1;
    a0 = cs + {8'h00, ip};
    a1 = cs + {8'h00, ipx};
    b0 = code_byte(a0);
    b1 = code_byte(a1);
    disp = (nbytes == 1) ? {{8{b0[7]}}, b0} : (nbytes == 2) ? {b1, b0} : 16'h0;
    off = base + disp;
    seg = oe ? ob : (use_bp ? ss : ds);
    lin = seg + {8'h00, off};

    @(negedge clk);
    nfetch = 0;
    addr_byte = ab; reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
    ip_in = ip; cs_base = cs; ds_base = ds; ss_base = ss;
    seg_ovr_en = oe; seg_ovr_base = ob;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      // different operands while busy: must be ignored (R12)
      addr_byte = 8'h00; reg_bx = ~bx; reg_si = ~si; ip_in = ~ip; ds_base = ~ds; ss_base = ~ss;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (nbytes == 0 && !mid_start)
      chk(n == 0, "R6 latency", n, 0);
    chk(done, "R10 done seen", done, 1);
    if (mode == 3) begin
      chk(err == 1'b1, "R11 err", err, 1);
      chk(ip_out == ip, "R11 ip", ip_out, ip);
      chk(nfetch == 0, "R11 no read", nfetch, 0);
    end else begin
      chk(err == 1'b0, "R11 err low", err, 0);
      chk(ea_offset == off, mid_start ? "R12 offset" : "R1 R7 offset", ea_offset, off);
      chk(ea_seg == seg, oe ? "R3 seg" : "R2 seg", ea_seg, seg);
      chk(ea_linear == lin, "R7 linear", ea_linear, lin);
      chk(ip_out == ip + 16'(nbytes), nbytes == 1 ? "R4 ip" : nbytes == 2 ? "R5 ip" : "R6 ip",
          ip_out, ip + 16'(nbytes));
      chk(nfetch == nbytes, "R6 read count", nfetch, nbytes);
      if (nbytes >= 1) chk(fa0 == a0, "R8 addr lo", fa0, a0);
      if (nbytes == 2) chk(fa1 == a1, "R8 addr hi", fa1, a1);
    end
    @(negedge clk);
    chk(!done, "R10 pulse", done, 0);
    chk(ea_linear == lin || mode == 3, "R10 hold", ea_linear, lin);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(done == 0 && rd_req == 0 && err == 0, "R13 ctrl", {done, rd_req, err}, 0);
    chk(ea_offset == 0 && ea_linear == 0 && ea_seg == 0 && ip_out == 0, "R13 results",
        ea_linear, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // every legal form once
    for (int m = 0; m < 3; m++)
      for (int r = 0; r < 8; r++)
        run_op({m[1:0], 3'b000, r[2:0]}, $urandom, $urandom, $urandom, $urandom, $urandom,
               $urandom, $urandom, $urandom, 0, 0, 0);

    // R7 offset wrap then linear wrap
    run_op(8'h00, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 16'h100, 24'h0, 24'h001000, 24'h0, 0, 0, 0);
    run_op(8'h07, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h100, 24'h0, 24'hFFC000, 24'h0, 0, 0, 0);
    // R4 negative byte displacement
    poke_en = 1; poke_addr = 24'h020040; poke_val = 8'h80;
    run_op(8'h44, 16'h0, 16'h0, 16'h0010, 16'h0, 16'h0040, 24'h020000, 24'h0, 24'h0, 0, 0, 0);
    poke_en = 0;
    // R8 IP wrap between the two bytes
    run_op(8'h85, 16'h0, 16'h0, 16'h0, 16'h1234, 16'hFFFF, 24'h030000, 24'h0, 24'h0, 0, 0, 0);
    // R5 direct form uses DS and no base; R2 BP forms use SS
    run_op(8'h06, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0500, 24'h010000, 24'h040000,
           24'h080000, 0, 0, 0);
    run_op(8'h46, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h0500, 24'h010000, 24'h040000,
           24'h080000, 0, 0, 0);
    // R3 override
    run_op(8'h02, 16'h1, 16'h2, 16'h3, 16'h4, 16'h0, 24'h0, 24'h040000, 24'h080000, 1,
           24'h0C0000, 0);
    // R11 register-direct
    run_op(8'hC3, 16'h1, 16'h2, 16'h3, 16'h4, 16'h0777, 24'h0, 24'h0, 24'h0, 0, 0, 0);
    // R12 start while busy
    force_lat = 4;
    run_op(8'h81, 16'h0100, 16'h0, 16'h0, 16'h0020, 16'h0200, 24'h050000, 24'h060000, 24'h0,
           0, 0, 1);
    force_lat = -1;
    // R9 stray valid pulses while idle change nothing
    begin
      logic [AW-1:0] keep;
      keep = ea_linear;
      spur_en = 1;
      repeat (5) @(negedge clk);
      spur_en = 0;
      @(negedge clk);
      chk(ea_linear == keep && !done, "R9 stray valid", ea_linear, keep);
    end

    // random mix
    for (int i = 0; i < 300; i++)
      run_op(8'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, ($urandom % 4) == 0, $urandom, 0);

    summary();
  end

endmodule